// File: doc/BRIEF.md
# Oscillator Enable and Ready Controller

This block controls a single clock oscillator from a register clock domain. Software writes a control word that holds a run bit, a bypass bit, a drive-strength code and a ready-interrupt enable. When the run bit is set, the oscillator domain counts a fixed number of oscillator cycles to model startup. It then reports the oscillator as stable. That report passes through a synchronizer into the register domain, where it appears as the ready flag.

The gated clock output is released only after the ready flag has been set. The ready state is carried back into the oscillator domain for this purpose, and the output gate opens on a falling oscillator edge. Clearing the run bit drops the ready flag at once. The output then closes on a falling edge, so the last pulse is never cut short.

Drive-strength writes follow an asymmetric rule. While the oscillator runs, a write may lower the code but cannot raise it. While the oscillator is stopped, any code may be written. In bypass mode an external clock replaces the crystal, and the startup wait is much shorter.

Top module: `osc_ready_ctrl`

## Requirements
- R1: After reset, osc_on, osc_bypass, drive_lvl, irq_en, ready, irq_flag, irq and clk_out are all 0.
- R2: A write (wr_en=1) that arrives while osc_on is 0 loads wr_drive into drive_lvl and wr_bypass into osc_bypass, whatever their values.
- R3: A write that arrives while osc_on is 1 loads wr_drive only if it is numerically lower than drive_lvl; otherwise drive_lvl keeps its value. Code 0 is the weakest drive and code 3 the strongest. The test uses the run bit as it stood before the write, so a write that also clears the run bit is still filtered.
- R4: In crystal mode (osc_bypass=0), ready rises no earlier than XTAL_CYCLES rising edges of osc_clk after the clk edge that set osc_on, and no later than XTAL_CYCLES+6 such edges.
- R5: clk_out stays low until ready is 1. Once ready is set, clk_out follows osc_clk.
- R6: irq_flag becomes 1 in the clk cycle after ready rises, but only if irq_en is 1 at that time. It stays set until it is cleared. irq equals irq_flag AND irq_en.
- R7: A one-cycle irq_clr pulse clears irq_flag on the next clk edge.
- R8: A write with wr_on=0 drives osc_on and ready to 0 after the clk edge that takes the write.
- R9: After the run bit is cleared, clk_out is held low within a few osc_clk cycles. Every high pulse of clk_out lasts a full half period of osc_clk.
- R10: In bypass mode (osc_bypass=1 and osc_on=1), ready rises between BYP_CYCLES and BYP_CYCLES+6 rising edges of osc_clk after enable.
- R11: A write that arrives while osc_on is 1 leaves osc_bypass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Free-running oscillator clock |
| wr_en | input | 1 | Control-word write strobe |
| wr_on | input | 1 | Run bit to write |
| wr_bypass | input | 1 | Bypass bit to write |
| wr_drive | input | DRV_W | Drive-strength code to write |
| wr_irq_en | input | 1 | Ready-interrupt enable to write |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| osc_on | output | 1 | Current run bit |
| osc_bypass | output | 1 | Current bypass bit |
| drive_lvl | output | DRV_W | Current drive-strength code |
| irq_en | output | 1 | Current ready-interrupt enable |
| ready | output | 1 | Oscillator stable, in the register domain |
| irq_flag | output | 1 | Sticky ready-interrupt flag |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Gated oscillator clock |

## Verification
Register fields such as the run bit, bypass bit and drive code take effect on the clk edge after the write strobe. The bench reads them on the following falling clk edge, and irq_flag one clk cycle later still. The ready flag arrives after two oscillator-domain synchronizer stages, the startup count and two register-domain stages. Because the two clocks are unrelated, the bench counts osc_clk rising edges from the enabling write and requires the count at ready to fall inside a fixed window above the startup count. Gating of clk_out lags ready by about three oscillator cycles. The bench therefore watches clk_out for early pulses during the whole startup, and checks for a stopped output only after ten oscillator cycles have passed since disable.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

   // Startup phase of the oscillator-domain timer
   typedef enum logic [1:0] {
      PH_OFF    = 2'd0,
      PH_WARM   = 2'd1,
      PH_STABLE = 2'd2
   } osc_phase_e;

   // Stages used on every domain crossing in this block
   localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/osc_sync_stages.sv
module osc_sync_stages #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("osc_sync_stages: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs #(
   parameter int unsigned DRV_W   = 2,
   parameter logic [DRV_W-1:0] DRV_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_on,
   input  logic             wr_bypass,
   input  logic [DRV_W-1:0] wr_drive,
   input  logic             wr_irq_en,
   output logic             on_q,
   output logic             byp_q,
   output logic [DRV_W-1:0] drv_q,
   output logic             ien_q
);
   if (DRV_W < 1) begin : g_bad_width
      $error("osc_cfg_regs: DRV_W must be at least 1");
   end

   // Lowering is always allowed; raising only while stopped
   logic drv_lower;
   assign drv_lower = (wr_drive < drv_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         byp_q <= 1'b0;
         drv_q <= DRV_RST;
         ien_q <= 1'b0;
      end else if (wr_en) begin
         on_q  <= wr_on;
         ien_q <= wr_irq_en;
         if (!on_q) begin
            byp_q <= wr_bypass;
            drv_q <= wr_drive;
         end else if (drv_lower) begin
            drv_q <= wr_drive;
         end
      end
   end
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned XTAL_CYCLES = 4096,
   parameter int unsigned BYP_CYCLES  = 8,
   parameter int unsigned SYNC_DEPTH  = 2
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic byp_req,
   output logic on_osc,
   output logic byp_osc,
   output logic stable
);
   localparam int unsigned CNT_W = $clog2(XTAL_CYCLES + 1);

   if (BYP_CYCLES < 2) begin : g_bad_byp
      $error("osc_startup_timer: BYP_CYCLES must be at least 2");
   end
   if (XTAL_CYCLES <= BYP_CYCLES) begin : g_bad_xtal
      $error("osc_startup_timer: XTAL_CYCLES must exceed BYP_CYCLES");
   end

   osc_sync_stages #(.STAGES(SYNC_DEPTH)) u_on_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(on_req), .q(on_osc)
   );
   osc_sync_stages #(.STAGES(SYNC_DEPTH)) u_byp_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(byp_req), .q(byp_osc)
   );

   osc_phase_e       phase;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = byp_osc ? CNT_W'(BYP_CYCLES) : CNT_W'(XTAL_CYCLES);

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_OFF;
         cnt   <= '0;
      end else if (!on_osc) begin
         phase <= PH_OFF;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_OFF: begin
               phase <= PH_WARM;
               cnt   <= CNT_W'(1);
            end
            PH_WARM: begin
               if (cnt == limit - CNT_W'(1)) phase <= PH_STABLE;
               else                          cnt   <= cnt + CNT_W'(1);
            end
            default: phase <= PH_STABLE;
         endcase
      end
   end

   assign stable = (phase == PH_STABLE);
endmodule

// File: rtl/osc_clk_gate.sv
module osc_clk_gate (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic en,
   output logic gate_on,
   output logic clk_out
);
   // Enable changes only while osc_clk is low, so the AND never cuts a pulse
   always_ff @(negedge osc_clk or negedge rst_n) begin
      if (!rst_n) gate_on <= 1'b0;
      else        gate_on <= en;
   end

   assign clk_out = osc_clk & gate_on;
endmodule

// File: rtl/osc_ready_ctrl.sv
module osc_ready_ctrl
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned XTAL_CYCLES = 4096,
   parameter int unsigned BYP_CYCLES  = 8,
   parameter int unsigned DRV_W       = 2,
   parameter int unsigned SYNC_DEPTH  = SYNC_DEPTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_clk,
   input  logic             wr_en,
   input  logic             wr_on,
   input  logic             wr_bypass,
   input  logic [DRV_W-1:0] wr_drive,
   input  logic             wr_irq_en,
   input  logic             irq_clr,
   output logic             osc_on,
   output logic             osc_bypass,
   output logic [DRV_W-1:0] drive_lvl,
   output logic             irq_en,
   output logic             ready,
   output logic             irq_flag,
   output logic             irq,
   output logic             clk_out
);
   logic on_osc, byp_osc, osc_stable;
   logic ready_raw, ready_d, ready_back, gate_on;

   osc_cfg_regs #(.DRV_W(DRV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_on(wr_on),
      .wr_bypass(wr_bypass), .wr_drive(wr_drive), .wr_irq_en(wr_irq_en),
      .on_q(osc_on), .byp_q(osc_bypass), .drv_q(drive_lvl), .ien_q(irq_en)
   );

   osc_startup_timer #(
      .XTAL_CYCLES(XTAL_CYCLES), .BYP_CYCLES(BYP_CYCLES), .SYNC_DEPTH(SYNC_DEPTH)
   ) u_timer (
      .osc_clk(osc_clk), .rst_n(rst_n), .on_req(osc_on), .byp_req(osc_bypass),
      .on_osc(on_osc), .byp_osc(byp_osc), .stable(osc_stable)
   );

   // Stable report into the register domain
   osc_sync_stages #(.STAGES(SYNC_DEPTH)) u_rdy_sync (
      .clk(clk), .rst_n(rst_n), .d(osc_stable), .q(ready_raw)
   );

   assign ready = ready_raw & osc_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_d  <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         ready_d <= ready;
         if (ready && !ready_d && irq_en) irq_flag <= 1'b1;
         else if (irq_clr)                irq_flag <= 1'b0;
      end
   end

   assign irq = irq_flag & irq_en;

   // Ready flag returns to the oscillator side before the gate opens
   osc_sync_stages #(.STAGES(SYNC_DEPTH)) u_back_sync (
      .clk(osc_clk), .rst_n(rst_n), .d(ready), .q(ready_back)
   );

   osc_clk_gate u_gate (
      .osc_clk(osc_clk), .rst_n(rst_n), .en(ready_back & osc_stable),
      .gate_on(gate_on), .clk_out(clk_out)
   );
endmodule

// File: rtl/osc_ready_ctrl_chk.sv
module osc_ready_ctrl_chk #(
   parameter int unsigned XTAL_CYCLES = 4096,
   parameter int unsigned BYP_CYCLES  = 8,
   parameter int unsigned DRV_W       = 2
) (
   input logic             clk,
   input logic             osc_clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             irq_clr,
   input logic             osc_on,
   input logic             osc_bypass,
   input logic [DRV_W-1:0] drive_lvl,
   input logic             irq_en,
   input logic             ready,
   input logic             irq_flag,
   input logic             gate_on,
   input logic             osc_stable,
   input logic             on_osc,
   input logic             byp_osc
);
   localparam int unsigned CW = $clog2(XTAL_CYCLES + 2) + 1;

   logic [CW-1:0] cyc;
   logic [CW-1:0] want;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)                      cyc <= '0;
      else if (!on_osc)                cyc <= '0;
      else if (cyc != CW'(XTAL_CYCLES + 1)) cyc <= cyc + CW'(1);
   end

   assign want = byp_osc ? CW'(BYP_CYCLES) : CW'(XTAL_CYCLES);

   // R3
   drive_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && osc_on) |=> (drive_lvl <= $past(drive_lvl)));

   // R11
   bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && osc_on) |=> $stable(osc_bypass));

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> ($past(ready) && $past(irq_en)));

   // R7
   irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !ready) |=> !irq_flag);

   // R8
   off_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_on) |-> !ready);

   // R4 R10
   startup_count_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(osc_stable) |-> (cyc == want));

   // R5
   gate_needs_stable_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
      gate_on |-> osc_stable);
endmodule

bind osc_ready_ctrl osc_ready_ctrl_chk #(
   .XTAL_CYCLES(XTAL_CYCLES), .BYP_CYCLES(BYP_CYCLES), .DRV_W(DRV_W)
) u_chk (
   .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en),
   .irq_clr(irq_clr), .osc_on(osc_on), .osc_bypass(osc_bypass),
   .drive_lvl(drive_lvl), .irq_en(irq_en), .ready(ready),
   .irq_flag(irq_flag), .gate_on(gate_on), .osc_stable(osc_stable),
   .on_osc(on_osc), .byp_osc(byp_osc)
);

// File: tb/osc_ready_ctrl_tb.sv
module osc_ready_ctrl_tb;
   localparam int XTAL = 64;
   localparam int BYP  = 8;
   localparam int DW   = 2;

   logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_on = 1'b0, wr_bypass = 1'b0, wr_irq_en = 1'b0, irq_clr = 1'b0;
   logic [DW-1:0] wr_drive = '0;
   logic osc_on, osc_bypass, irq_en, ready, irq_flag, irq, clk_out;
   logic [DW-1:0] drive_lvl;

   int checks = 0, errors = 0;
   int osc_edges = 0, gclk_edges = 0, early_pulses = 0, runts = 0;
   bit watching = 1'b0;
   realtime rise_t = 0.0;

   always #5  clk     = ~clk;
   always #13 osc_clk = ~osc_clk;

   osc_ready_ctrl #(.XTAL_CYCLES(XTAL), .BYP_CYCLES(BYP), .DRV_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .wr_en(wr_en), .wr_on(wr_on),
      .wr_bypass(wr_bypass), .wr_drive(wr_drive), .wr_irq_en(wr_irq_en),
      .irq_clr(irq_clr), .osc_on(osc_on), .osc_bypass(osc_bypass),
      .drive_lvl(drive_lvl), .irq_en(irq_en), .ready(ready), .irq_flag(irq_flag),
      .irq(irq), .clk_out(clk_out)
   );

   always @(posedge osc_clk) osc_edges++;
   always @(posedge clk_out) begin
      gclk_edges++;
      rise_t = $realtime;
      if (watching && !ready) early_pulses++;
   end
   always @(negedge clk_out) if ($realtime - rise_t < 12.5) runts++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit on, input bit byp, input int drv, input bit ien);
      @(negedge clk);
      wr_en = 1'b1; wr_on = on; wr_bypass = byp; wr_drive = DW'(drv); wr_irq_en = ien;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Returns osc edges from the enabling write until ready, or -1 on timeout
   task automatic start_and_wait(input bit byp, input bit ien, output int edges);
      int t0;
      watching = 1'b1;
      @(negedge clk);
      wr_en = 1'b1; wr_on = 1'b1; wr_bypass = byp; wr_drive = '0; wr_irq_en = ien;
      @(posedge clk);
      t0 = osc_edges;
      @(negedge clk);
      wr_en = 1'b0;
      edges = -1;
      for (int i = 0; i < 4000; i++) begin
         if (ready) begin
            edges = osc_edges - t0;
            break;
         end
         @(negedge clk);
      end
      watching = 1'b0;
   endtask

   task automatic osc_wait(input int n);
      repeat (n) @(posedge osc_clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int e0, e_by, g0, ep0;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(osc_on == 0 && osc_bypass == 0 && irq_en == 0, "R1 ctrl", osc_on, 0);
      chk(drive_lvl == 0 && ready == 0 && irq_flag == 0 && irq == 0 && clk_out == 0,
          "R1 status", int'(ready), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 stopped: every code pair loads freely
      for (int c = 0; c < 4; c++)
         for (int n = 0; n < 4; n++) begin
            wr(0, 0, c, 0);
            wr(0, 0, n, 0);
            chk(drive_lvl == DW'(n), "R2 drive stopped", drive_lvl, n);
         end
      wr(0, 1, 0, 0);
      chk(osc_bypass == 1, "R2 bypass load", osc_bypass, 1);
      wr(0, 0, 0, 0);
      chk(osc_bypass == 0, "R2 bypass clear", osc_bypass, 0);

      // R3 running: only lower codes are taken
      for (int c = 0; c < 4; c++)
         for (int n = 0; n < 4; n++) begin
            wr(0, 0, c, 0);
            wr(1, 0, c, 0);
            wr(1, 0, n, 0);
            chk(drive_lvl == DW'((n < c) ? n : c), "R3 drive running", drive_lvl,
                (n < c) ? n : c);
         end
      // R3 a disabling write is still filtered
      wr(0, 0, 3, 0);
      wr(1, 0, 1, 0);
      wr(0, 0, 3, 0);
      chk(drive_lvl == 1, "R3 filter on disable", drive_lvl, 1);
      wr(0, 0, 0, 0);
      osc_wait(20);

      // R4 R5 R6 crystal startup with interrupt enabled
      early_pulses = 0;
      start_and_wait(0, 1, e0);
      chk(e0 >= XTAL && e0 <= XTAL + 6, "R4 startup window", e0, XTAL);
      chk(early_pulses == 0, "R5 no pulse before ready", early_pulses, 0);
      @(negedge clk);
      chk(irq_flag == 1 && irq == 1, "R6 irq on ready", int'(irq_flag), 1);
      g0 = gclk_edges;
      osc_wait(10);
      chk(gclk_edges - g0 >= 5, "R5 clock released", gclk_edges - g0, 10);

      // R11 bypass write ignored while running
      wr(1, 1, 0, 1);
      chk(osc_bypass == 0, "R11 bypass held", osc_bypass, 0);

      // R7 clear
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq_flag == 0 && irq == 0, "R7 irq cleared", irq_flag, 0);

      // R8 disable
      wr(0, 0, 0, 0);
      chk(osc_on == 0 && ready == 0, "R8 off drops ready", int'(ready), 0);

      // R9 output stops and stays low
      osc_wait(10);
      g0 = gclk_edges;
      osc_wait(10);
      chk(gclk_edges == g0 && clk_out == 0, "R9 clock stopped", gclk_edges - g0, 0);

      // R6 no flag when interrupt disabled
      osc_wait(10);
      start_and_wait(0, 0, e0);
      @(negedge clk);
      chk(ready == 1 && irq_flag == 0 && irq == 0, "R6 masked", irq_flag, 0);
      wr(0, 0, 0, 0);
      osc_wait(20);

      // R10 bypass startup
      wr(0, 1, 0, 0);
      ep0 = early_pulses;
      start_and_wait(1, 1, e_by);
      chk(e_by >= BYP && e_by <= BYP + 6, "R10 bypass window", e_by, BYP);
      chk(early_pulses == ep0, "R5 bypass no early pulse", early_pulses - ep0, 0);
      chk(osc_bypass == 1, "R10 bypass kept", osc_bypass, 1);
      osc_wait(10);
      wr(0, 0, 0, 0);
      osc_wait(20);

      // R9 no runt pulses anywhere in the run
      chk(runts == 0, "R9 runt pulses", runts, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule